// File: doc/BRIEF.md
# Configurable asynchronous serial transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. The character length (5 to 9 bits), the parity mode (none, even or odd) and the number of stop bits (one or two) are chosen through configuration inputs. The block captures these inputs when each frame begins, so software or upstream logic may change them while a frame is on the line.

Words arrive on a valid/ready handshake. Bit timing comes from an external one-cycle baud tick; every serial bit lasts sixteen of those ticks. While the final stop bit is on the line the block takes one more word into a single holding slot. That word's start bit then follows the last stop bit directly, so a steady producer gets frames with no idle time between them. A one-cycle `done` pulse marks the end of each frame, and `busy` stays high while a frame is on the line.

Top module: `async_tx`

## Requirements
- R1: A frame opens with one start bit driven low. Every bit of a frame lasts exactly 16 consumed baud ticks. The line is high whenever the block is not busy.
- R2: `cfg_len` selects the character length: codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits, and codes 5 to 7 give 9 bits.
- R3: Data bits are sent least significant first, and only the configured number of low bits of `in_data` is sent.
- R4: `cfg_parity` code 1 selects even parity and code 2 selects odd parity; codes 0 and 3 send no parity bit. With even parity the parity bit makes the number of ones among the sent data bits plus the parity bit even; with odd parity it makes that number odd. The parity bit sits between the last data bit and the first stop bit.
- R5: `cfg_two_stop` = 0 ends a frame with one high stop bit; `cfg_two_stop` = 1 ends it with two.
- R6: The data word and all configuration inputs are captured when a frame starts. Changes to them later in the frame have no effect on it.
- R7: `in_ready` is high while idle and during the final stop bit, until the holding slot is filled. A word accepted during the final stop bit has its start bit on the line in the cycle after the last stop bit ends, with no idle bits between.
- R8: `done` is a one-cycle pulse in the cycle after a frame's last stop bit ends. `busy` rises in the cycle after a word is accepted in idle and falls after a frame ends with no word waiting.
- R9: The line changes level only in the cycle after a consumed baud tick.
- R10: After reset the line is high, `busy` and `done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_ready | output | 1 | The block takes the offered word at this edge |
| in_data | input | 9 | Character; only the low configured bits are sent |
| cfg_len | input | 3 | Character length code (R2) |
| cfg_parity | input | 2 | Parity mode code (R4) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| baud_tick | input | 1 | One-cycle pulse, sixteen per serial bit |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | A frame is on the line |
| done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The hardest case to reach is a word that arrives during the final stop bit and is then sent with no gap. The hardest form of it is a word accepted in the very cycle the stop bit ends, so that the holding slot is bypassed. The stimulus keeps `in_valid` high with the next word while the current frame is still running, and it changes the stop-bit count and parity between frames. Since the tick runs every third clock, the acceptance cycle lands on different positions relative to the final tick. Between frames the configuration inputs are deliberately altered after each frame has captured them. The monitor rebuilds every expected bit from the values in force at frame start and checks the level at the middle of each bit.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    localparam logic [1:0] PAR_NONE = 2'd0;
    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

endpackage

// File: rtl/async_tx_parity.sv
module async_tx_parity #(
    parameter int DATA_W = 9,
    parameter int NB_W   = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [NB_W-1:0]   nbits,
    input  logic              odd_mode,
    output logic              par_bit
);
    logic [DATA_W-1:0] mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (nbits > NB_W'(i));
    end

    assign par_bit = (^(data & mask)) ^ odd_mode;

endmodule

// File: rtl/async_tx_bitclk.sv
module async_tx_bitclk #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = $clog2(OVERSAMPLE);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        bit_end = run && tick && (cnt_q == CW'(OVERSAMPLE - 1));
        if (run && tick) begin
            cnt_d = bit_end ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int DATA_W     = 9,
    parameter int MIN_LEN    = 5,
    parameter int LEN_CODE_W = 3,
    parameter int OVERSAMPLE = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic [1:0]            cfg_parity,
    input  logic                  cfg_two_stop,
    input  logic                  baud_tick,
    output logic                  tx_line,
    output logic                  busy,
    output logic                  done
);
    localparam int CNT_W    = $clog2(DATA_W + 1);
    localparam int MAX_CODE = DATA_W - MIN_LEN;

    typedef struct packed {
        tx_state_e          st;
        logic [DATA_W-1:0]  sh;
        logic [CNT_W-1:0]   len;
        logic [CNT_W-1:0]   left;
        logic               par_en;
        logic               par_bit;
        logic               two_stop;
        logic               last_stop;
        logic               pend_vld;
        logic [DATA_W-1:0]  pend;
        logic               done;
    } regs_t;

    regs_t q, d;

    logic              bit_end;
    logic              accept;
    logic              start;
    logic [DATA_W-1:0] src;
    logic [CNT_W-1:0]  len_sel;
    logic              new_par;

    // character length chosen by the code on the pins
    always_comb begin
        if (int'(cfg_len) > MAX_CODE) len_sel = CNT_W'(DATA_W);
        else                          len_sel = CNT_W'(MIN_LEN) + CNT_W'(cfg_len);
    end

    assign src = q.pend_vld ? q.pend : in_data;

    async_tx_parity #(
        .DATA_W (DATA_W),
        .NB_W   (CNT_W)
    ) u_par (
        .data     (src),
        .nbits    (len_sel),
        .odd_mode (cfg_parity == PAR_ODD),
        .par_bit  (new_par)
    );

    async_tx_bitclk #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.st != ST_IDLE),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    assign in_ready = (q.st == ST_IDLE) ||
                      (q.st == ST_STOP && q.last_stop && !q.pend_vld);
    assign accept   = in_valid && in_ready;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        start  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) start = 1'b1;
            end
            ST_START: begin
                if (bit_end) begin
                    d.st   = ST_DATA;
                    d.left = q.len - CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    d.sh = q.sh >> 1;
                    if (q.left == '0) begin
                        d.st        = q.par_en ? ST_PAR : ST_STOP;
                        d.last_stop = !q.two_stop;
                    end else begin
                        d.left = q.left - CNT_W'(1);
                    end
                end
            end
            ST_PAR: begin
                if (bit_end) begin
                    d.st        = ST_STOP;
                    d.last_stop = !q.two_stop;
                end
            end
            ST_STOP: begin
                if (accept) begin
                    d.pend_vld = 1'b1;
                    d.pend     = in_data;
                end
                if (bit_end) begin
                    if (!q.last_stop) begin
                        d.last_stop = 1'b1;
                    end else begin
                        d.done = 1'b1;
                        if (q.pend_vld || accept) start = 1'b1;
                        else                      d.st  = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (start) begin
            d.st       = ST_START;
            d.sh       = src;
            d.len      = len_sel;
            d.par_en   = (cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD);
            d.par_bit  = new_par;
            d.two_stop = cfg_two_stop;
            d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = q.sh[0];
            ST_PAR:   tx_line = q.par_bit;
            default:  tx_line = 1'b1;
        endcase
    end

    assign busy = (q.st != ST_IDLE);
    assign done = q.done;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic baud_tick,
    input logic tx_line,
    input logic busy,
    input logic done
);
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line); // R1

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line); // R1

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !busy) |=> busy); // R8

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(tx_line)); // R9

    AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(baud_tick)); // R9

endmodule

bind async_tx async_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .baud_tick (baud_tick),
    .tx_line   (tx_line),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_async_tx.sv
`timescale 1ns/1ps
module sim_async_tx;

    typedef struct {
        logic [8:0] data;
        int         len;
        int         par;
        bit         two;
        bit         gapless;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic [2:0] cfg_len = '0;
    logic [1:0] cfg_parity = '0;
    logic       cfg_two_stop = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_line, busy, done;

    int    n_checks = 0;
    int    n_fail = 0;
    int    tick_total = 0;
    bit    mon_active = 1'b0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    async_tx u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
        .cfg_two_stop(cfg_two_stop), .baud_tick(baud_tick),
        .tx_line(tx_line), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // requirement-side decode of the length code (R2) and parity code (R4)
    function automatic int dec_len(input logic [2:0] c);
        return (c > 3'd4) ? 9 : 5 + int'(c);
    endfunction

    function automatic int dec_par(input logic [1:0] c);
        return (c == 2'd1 || c == 2'd2) ? int'(c) : 0;
    endfunction

    // baud tick every third clock
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            baud_tick = (phase == 2);
            phase = (phase + 1) % 3;
        end
    end

    always @(posedge clk) if (baud_tick) tick_total <= tick_total + 1;

    // driver: pushes the expected item when the word is taken
    task automatic send(input logic [8:0] dv, input logic [2:0] lc,
                        input logic [1:0] pc, input bit ts);
        item_t it;
        bit    gl;
        @(negedge clk);
        cfg_len = lc; cfg_parity = pc; cfg_two_stop = ts;
        in_data = dv; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        gl = busy;
        @(posedge clk);
        it.data = dv; it.len = dec_len(lc); it.par = dec_par(pc);
        it.two = ts; it.gapless = gl;
        exp_q.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
        in_data = ~dv;
        if (!gl) chk("R8 busy after idle accept", int'(busy), 1);
        while (!done && gl) @(negedge clk);
        // R6: alter every input once the frame has captured them
        cfg_len = lc ^ 3'd3;
        cfg_parity = pc ^ 2'd1;
        cfg_two_stop = ~ts;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || exp_q.size() != 0 || mon_active);
    endtask

    // monitor: rebuilds each frame and samples mid-bit
    initial begin
        bit  chain = 1'b0;
        int  t0 = 0;
        forever begin
            item_t it;
            logic  bits[16];
            int    nb, ones;
            if (!chain) begin
                do @(negedge clk); while (tx_line !== 1'b0);
                t0 = tick_total;
            end
            mon_active = 1'b1;
            if (exp_q.size() == 0) begin
                chk("R1 unexpected start bit", 1, 0);
                chain = 1'b0;
                mon_active = 1'b0;
                continue;
            end
            it = exp_q.pop_front();
            nb = 0; ones = 0;
            bits[nb++] = 1'b0;
            for (int i = 0; i < it.len; i++) begin
                bits[nb++] = it.data[i];
                ones += int'(it.data[i]);
            end
            if (it.par == 1) bits[nb++] = ones[0];
            if (it.par == 2) bits[nb++] = ~ones[0];
            bits[nb++] = 1'b1;
            if (it.two) bits[nb++] = 1'b1;
            for (int k = 0; k < nb; k++) begin
                wait (tick_total == t0 + 16 * k + 8);
                @(negedge clk);
                if (k == 0)
                    chk("R1 start bit low", int'(tx_line), 0);
                else if (k <= it.len)
                    chk("R3 data bit order", int'(tx_line), int'(bits[k]));
                else if (it.par != 0 && k == it.len + 1)
                    chk("R4 parity bit", int'(tx_line), int'(bits[k]));
                else
                    chk("R5 stop bit high", int'(tx_line), 1);
            end
            wait (tick_total == t0 + 16 * nb);
            @(negedge clk);
            chk("R8 done pulse at frame end", int'(done), 1);
            t0 = t0 + 16 * nb;
            chain = (exp_q.size() != 0) && exp_q[0].gapless;
            if (chain) begin
                chk("R7 gapless start bit", int'(tx_line), 0);
            end else begin
                chk("R1 idle high after frame", int'(tx_line), 1);
                chk("R8 busy low after frame", int'(busy), 0);
            end
            mon_active = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 line high", int'(tx_line), 1);
        chk("R10 busy low", int'(busy), 0);
        chk("R10 done low", int'(done), 0);
        chk("R10 ready high", int'(in_ready), 1);

        send(9'h0B5, 3'd3, 2'd0, 1'b0); wait_idle();  // R3 eight bits, no parity
        send(9'h013, 3'd0, 2'd1, 1'b1); wait_idle();  // R2 five bits, even, R5 two stops
        send(9'h1A6, 3'd4, 2'd2, 1'b0); wait_idle();  // R2 nine bits, odd
        send(9'h1FF, 3'd1, 2'd2, 1'b1); wait_idle();  // R3 upper bits not sent or counted
        send(9'h055, 3'd2, 2'd1, 1'b0); wait_idle();  // R4 seven bits, even
        send(9'h1C3, 3'd7, 2'd0, 1'b0); wait_idle();  // R2 code 7 gives nine bits
        send(9'h0F0, 3'd3, 2'd3, 1'b0); wait_idle();  // R4 code 3 sends no parity
        send(9'h000, 3'd3, 2'd2, 1'b1); wait_idle();  // R4 odd parity of zero data

        // R7 back-to-back frames with changing format
        send(9'h15A, 3'd4, 2'd1, 1'b0);
        send(9'h0A5, 3'd3, 2'd2, 1'b1);
        send(9'h01E, 3'd0, 2'd0, 1'b0);
        send(9'h1FF, 3'd4, 2'd2, 1'b1);
        send(9'h036, 3'd1, 2'd1, 1'b0);
        wait_idle();

        @(negedge clk);
        chk("R1 line high at end", int'(tx_line), 1);
        chk("R7 ready high at end", int'(in_ready), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule